// File: doc/BRIEF.md
# Flash Operating-Mode Control Register with Write Interlock

This block holds the 8-bit control word that puts an on-chip flash array into one of its operating modes: program, erase, program-verify, erase-verify, or plain read. Software reaches a mode only by a fixed sequence of writes. First it sets a software enable. Then it sets a setup or verify bit. For program and erase, it then sets the action bit. Each bit of the word has its own write-permission condition, built from an external hardware write-enable pin level and from other bits already held in the register.

The pin level shows up as the top bit of the word and cannot be written. A low pin clears every other bit at once. A system reset, a hardware standby or a software standby also clears the word. While the flash is disabled, reads return zero and writes are dropped. The decoded mode lines go to the flash controller, which owns the timing and the pulse generation.

Top module: `fmc_ctl`

## Requirements
- R1: After reset, and on the clock edge after hardware standby or software standby is asserted, bits 6..0 are 0. A read then returns 0x80 while the pin is high and 0x00 while it is low.
- R2: Read bit 7 always equals the current pin level, and writes to bit 7 have no effect.
- R3: Bit 6 (software enable) takes the written value only while the pin is high.
- R4: Bits 5 (erase setup), 4 (program setup), 3 (erase-verify) and 2 (program-verify) take the written value only when the pin is high and bit 6 was 1 before the write.
- R5: Bit 1 (erase) is writable only when the pin is high and bits 6 and 5 were 1 before the write. Bit 0 (program) is writable only when the pin is high and bits 6 and 4 were 1 before the write. In one write, each bit is judged on its own, and a refused bit keeps its old value.
- R6: A write that leaves bit 6 at 0 also clears bits 5..0 in that same write, so bits 5..0 are never nonzero while bit 6 is 0.
- R7: While the pin is low, bits 6..0 read as 0 and the program, erase and both verify mode outputs are low in that same cycle. The stored bits are cleared at the next clock edge.
- R8: While the flash is disabled, reads return 0x00, all mode outputs are low, and writes leave the stored word unchanged.
- R9: The mode outputs are one-hot or all low, decoded as follows. Program is bit 0. Erase is bit 1 with bit 0 clear. Program-verify is bit 2 with bits 1..0 clear. Erase-verify is bit 3 with bits 2..0 clear. Read is asserted exactly when bits 6..0 are all 0.
- R10: The read data is 0x00 whenever the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_wen | input | 1 | Hardware flash write-enable pin level |
| hw_stby | input | 1 | Hardware standby indication, clears the word |
| sw_stby | input | 1 | Software standby indication, clears the word |
| flash_on | input | 1 | On-chip flash enabled |
| wr_en | input | 1 | Bus write strobe |
| wr_data | input | 8 | Bus write data |
| rd_en | input | 1 | Bus read strobe |
| rd_data | output | 8 | Register read value |
| mode_prog | output | 1 | Program mode |
| mode_erase | output | 1 | Erase mode |
| mode_pverify | output | 1 | Program-verify mode |
| mode_everify | output | 1 | Erase-verify mode |
| mode_read | output | 1 | Normal read mode |

## Verification
Some properties are checked on every cycle: the mode lines stay one-hot, the action lines are dead while the pin is low, bits 5..0 are empty while the software enable is clear, a standby empties the word, and a dropped write leaves the word stable while the flash is off. Further checks cover transitions. The program bit may rise only if program setup, the software enable and the pin were set the cycle before. The erase bit may rise only if erase setup, the software enable and the pin were set the cycle before. Only the bench scenarios can show the exact per-bit result of an arbitrary write data byte applied on top of each reachable starting word. The same holds for the reset values under both pin levels, and for the contents kept across a period with the flash disabled.

// File: rtl/fmc_pkg.sv
package fmc_pkg;
  localparam int CTL_W       = 8;
  localparam int LOW_W       = CTL_W - 1;
  localparam int ACT_W       = LOW_W - 1;
  localparam int SYNC_STAGES = 2;

  // bit positions are software visible
  localparam int B_PIN = 7;
  localparam int B_SWE = 6;
  localparam int B_ESU = 5;
  localparam int B_PSU = 4;
  localparam int B_EVF = 3;
  localparam int B_PVF = 2;
  localparam int B_ERS = 1;
  localparam int B_PRG = 0;

  typedef enum logic [2:0] {
    MODE_READ,
    MODE_PROG,
    MODE_ERASE,
    MODE_PVFY,
    MODE_EVFY,
    MODE_IDLE
  } fmode_e;
endpackage

// File: rtl/fmc_rst_sync.sv
module fmc_rst_sync
  import fmc_pkg::*;
(
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/fmc_wr_gate.sv
module fmc_wr_gate
  import fmc_pkg::*;
(
  input  logic             pin,
  input  logic             wr_go,
  input  logic [LOW_W-1:0] cur,
  input  logic [LOW_W-1:0] din,
  output logic [LOW_W-1:0] nxt
);
  logic             swe_nxt;
  logic [ACT_W-1:0] low_nxt;

  // software enable depends only on the pin
  assign swe_nxt = (wr_go && pin) ? din[B_SWE] : cur[B_SWE];

  for (genvar b = 0; b < ACT_W; b++) begin : g_bit
    logic chain_ok;
    if (b == B_ERS) begin : g_ers
      assign chain_ok = cur[B_ESU];
    end else if (b == B_PRG) begin : g_prg
      assign chain_ok = cur[B_PSU];
    end else begin : g_plain
      assign chain_ok = 1'b1;
    end
    assign low_nxt[b] = (wr_go && pin && cur[B_SWE] && chain_ok) ? din[b] : cur[b];
  end

  // dropping the software enable empties the lower field
  assign nxt = {swe_nxt, low_nxt & {ACT_W{swe_nxt}}};
endmodule

// File: rtl/fmc_mode_dec.sv
module fmc_mode_dec
  import fmc_pkg::*;
(
  input  logic [LOW_W-1:0] bits,
  output fmode_e           mode
);
  always_comb begin
    if (bits == '0)          mode = MODE_READ;
    else if (bits[B_PRG])    mode = MODE_PROG;
    else if (bits[B_ERS])    mode = MODE_ERASE;
    else if (bits[B_PVF])    mode = MODE_PVFY;
    else if (bits[B_EVF])    mode = MODE_EVFY;
    else                     mode = MODE_IDLE;
  end
endmodule

// File: rtl/fmc_ctl.sv
module fmc_ctl
  import fmc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_wen,
  input  logic             hw_stby,
  input  logic             sw_stby,
  input  logic             flash_on,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [CTL_W-1:0] rd_data,
  output logic             mode_prog,
  output logic             mode_erase,
  output logic             mode_pverify,
  output logic             mode_everify,
  output logic             mode_read
);
  logic             rst_n_s;
  logic [LOW_W-1:0] r_q;
  logic [LOW_W-1:0] q_d;
  logic             q_en;
  logic [LOW_W-1:0] eff;
  logic [LOW_W-1:0] gate_nxt;
  logic             stby;
  logic             wr_go;
  fmode_e           mode;
  logic             unused_bit7;

  assign unused_bit7 = wr_data[B_PIN];

  fmc_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  // a low pin masks the stored bits combinationally
  assign eff   = r_q & {LOW_W{pin_wen}};
  assign stby  = hw_stby | sw_stby;
  assign wr_go = wr_en & flash_on & ~stby;

  fmc_wr_gate u_gate (
    .pin   (pin_wen),
    .wr_go (wr_go),
    .cur   (eff),
    .din   (wr_data[LOW_W-1:0]),
    .nxt   (gate_nxt)
  );

  always_comb begin
    q_en = wr_go | stby | (~pin_wen & (|r_q));
    if (stby || !pin_wen) q_d = '0;
    else                  q_d = gate_nxt;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)  r_q <= '0;
    else if (q_en) r_q <= q_d;
  end

  fmc_mode_dec u_dec (
    .bits (eff),
    .mode (mode)
  );

  always_comb begin
    rd_data      = (rd_en && flash_on) ? {pin_wen, eff} : '0;
    mode_read    = flash_on && (mode == MODE_READ);
    mode_prog    = flash_on && (mode == MODE_PROG);
    mode_erase   = flash_on && (mode == MODE_ERASE);
    mode_pverify = flash_on && (mode == MODE_PVFY);
    mode_everify = flash_on && (mode == MODE_EVFY);
  end
endmodule

// File: rtl/fmc_ctl_chk.sv
module fmc_ctl_chk
  import fmc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             pin_wen,
  input logic             hw_stby,
  input logic             sw_stby,
  input logic             flash_on,
  input logic [LOW_W-1:0] r_q,
  input logic             mode_prog,
  input logic             mode_erase,
  input logic             mode_pverify,
  input logic             mode_everify,
  input logic             mode_read
);
  AST_STBY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_stby || sw_stby) |=> (r_q == '0)); // R1

  AST_SWE_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(r_q[B_SWE]) |-> $past(pin_wen)); // R3

  AST_PRG_NEEDS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(r_q[B_PRG]) |-> $past(r_q[B_PSU] && r_q[B_SWE] && pin_wen)); // R5

  AST_ERS_NEEDS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(r_q[B_ERS]) |-> $past(r_q[B_ESU] && r_q[B_SWE] && pin_wen)); // R5

  AST_LOW_EMPTY_NO_SWE: assert property (@(posedge clk) disable iff (!rst_n)
    !r_q[B_SWE] |-> (r_q[ACT_W-1:0] == '0)); // R6

  AST_PIN_LOW_NO_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_wen |-> !(mode_prog || mode_erase || mode_pverify || mode_everify)); // R7

  AST_OFF_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_on && pin_wen && !hw_stby && !sw_stby) |=> $stable(r_q)); // R8

  AST_MODES_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mode_read, mode_prog, mode_erase, mode_pverify, mode_everify})); // R9
endmodule

bind fmc_ctl fmc_ctl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pin_wen      (pin_wen),
  .hw_stby      (hw_stby),
  .sw_stby      (sw_stby),
  .flash_on     (flash_on),
  .r_q          (r_q),
  .mode_prog    (mode_prog),
  .mode_erase   (mode_erase),
  .mode_pverify (mode_pverify),
  .mode_everify (mode_everify),
  .mode_read    (mode_read)
);

// File: tb/test_fmc_ctl.sv
module test_fmc_ctl;
  logic       clk = 1'b0;
  logic       rst_n, pin_wen, hw_stby, sw_stby, flash_on, wr_en, rd_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       mode_prog, mode_erase, mode_pverify, mode_everify, mode_read;
  int         n_tests = 0;
  int         n_fail  = 0;
  bit         done    = 1'b0;

  always #2 clk = ~clk;

  fmc_ctl i_fmc_ctl (
    .clk(clk), .rst_n(rst_n), .pin_wen(pin_wen), .hw_stby(hw_stby),
    .sw_stby(sw_stby), .flash_on(flash_on), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .mode_prog(mode_prog),
    .mode_erase(mode_erase), .mode_pverify(mode_pverify),
    .mode_everify(mode_everify), .mode_read(mode_read)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // expected next bits 6..0 from the rules
  function automatic logic [6:0] model(input logic [6:0] old, input logic pin, input logic [7:0] d);
    logic [6:0] n;
    if (!pin) return 7'h00;
    n = old;
    n[6] = d[6];
    if (old[6]) n[5:2] = d[5:2];
    if (old[6] && old[5]) n[1] = d[1];
    if (old[6] && old[4]) n[0] = d[0];
    if (!n[6]) n[5:0] = 6'h00;
    return n;
  endfunction

  // {read, prog, erase, pverify, everify}
  function automatic logic [7:0] exp_modes(input logic [6:0] b);
    logic [4:0] m;
    m[4] = (b == 7'h00);
    m[3] = b[0];
    m[2] = b[1] & ~b[0];
    m[1] = b[2] & ~b[1] & ~b[0];
    m[0] = b[3] & ~b[2] & ~b[1] & ~b[0];
    return {3'b000, m};
  endfunction

  function automatic logic [7:0] got_modes();
    return {3'b000, mode_read, mode_prog, mode_erase, mode_pverify, mode_everify};
  endfunction

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; #1;
  endtask

  task automatic stby_pulse();
    @(negedge clk); sw_stby = 1'b1;
    @(negedge clk); sw_stby = 1'b0; #1;
  endtask

  task automatic build(input logic [6:0] s);
    stby_pulse();
    if (s != 7'h00) wr(8'h40);
    if (s == 7'h7C || s == 7'h7F || s == 7'h73) wr(s == 7'h73 ? 8'h70 : 8'h7C);
    if (s == 7'h7F || s == 7'h73) wr({1'b0, s});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [6:0] starts [4];
    starts[0] = 7'h00; starts[1] = 7'h40; starts[2] = 7'h7C; starts[3] = 7'h7F;
    rst_n = 1'b0; pin_wen = 1'b0; hw_stby = 1'b0; sw_stby = 1'b0;
    flash_on = 1'b1; wr_en = 1'b0; wr_data = 8'h00; rd_en = 1'b1;
    repeat (3) @(negedge clk);
    #1 chk("R1 reset pin low", rd_data, 8'h00);
    pin_wen = 1'b1;
    #1 chk("R1 reset pin high", rd_data, 8'h80);
    chk("R9 reset modes", got_modes(), 8'h10);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // sweep all write bytes from each reachable start
    foreach (starts[i]) begin
      for (int d = 0; d < 256; d++) begin
        logic [6:0] e;
        build(starts[i]);
        chk("R3 R4 R5 start", rd_data, {1'b1, starts[i]});
        wr(d[7:0]);
        e = model(starts[i], 1'b1, d[7:0]);
        chk("R2 R3 R4 R5 R6 write", rd_data, {1'b1, e});
        chk("R9 modes", got_modes(), exp_modes(e));
      end
    end

    // pin low: writes refused
    pin_wen = 1'b0;
    for (int d = 0; d < 256; d++) begin
      wr(d[7:0]);
      chk("R3 R7 pin low write", rd_data, 8'h00);
      chk("R7 pin low modes", got_modes(), 8'h10);
    end
    pin_wen = 1'b1;

    // pin drop is seen in the same cycle
    build(7'h73);
    chk("R9 program mode", got_modes(), 8'h08);
    @(negedge clk); pin_wen = 1'b0;
    #1 chk("R7 immediate read", rd_data, 8'h00);
    chk("R7 immediate modes", got_modes(), 8'h10);
    @(negedge clk); pin_wen = 1'b1;
    #1 chk("R7 cleared after edge", rd_data, 8'h80);

    // hardware standby
    build(7'h7C);
    @(negedge clk); hw_stby = 1'b1;
    @(negedge clk); hw_stby = 1'b0;
    #1 chk("R1 hw standby", rd_data, 8'h80);

    // flash disabled
    build(7'h40);
    flash_on = 1'b0;
    #1 chk("R8 off read", rd_data, 8'h00);
    chk("R8 off modes", got_modes(), 8'h00);
    wr(8'h7C);
    flash_on = 1'b1;
    #1 chk("R8 write dropped", rd_data, 8'hC0);

    // read strobe low
    rd_en = 1'b0;
    #1 chk("R10 no strobe", rd_data, 8'h00);
    rd_en = 1'b1;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule